// File: doc/BRIEF.md
# Shortened LDPC Codeword Framer

The framer wraps a quasi-cyclic LDPC encoder and turns its full-length subcode codeword into a transmitted frame that is 32-bit aligned.

On the information side, each encoder block is 7154 bits long. The framer feeds the encoder 18 zero bits first, then passes the 7136 user bits through. The user input is held off while the zeros go out.

On the codeword side, the framer works in four steps:
- It sends a 32-bit sync marker. The marker is not scrambled.
- It accepts the 18 codeword bits that hold the zero fill and discards them.
- It forwards the remaining 8158 codeword bits.
- It appends two transmitted zero bits.

All 8160 codeword bits, including the two appended bits, are XORed with an 8-stage pseudo-random sequence. The sequence restarts at the first codeword bit of every frame.

Both streams use a valid/ready handshake, one bit per transfer. The output handshake can stall the marker counter, the codeword counter and the scrambler together.

Top module: `ldpc_frm_top`

## Requirements
- R1: In every encoder block of 7154 positions, positions 0..17 carry 0 while `usr_ready_o` stays low. Positions 18..7153 carry the user bits in arrival order, each one handed over in the same cycle it is accepted. `enc_last_o` is high only at position 7153.
- R2: Every frame starts with the 32 bits of 0x1ACFFC1D, most significant bit first, sent without scrambling.
- R3: `frame_sof_o` is high on the first marker bit of a frame and at no other output bit.
- R4: The first 18 codeword bits of each 8176-bit codeword are accepted (`cw_ready_o` high) and never appear on the output. Codeword bits 18..8175 follow the marker in order.
- R5: The k-th output bit after the marker (k = 0..8159) is the codeword content XOR p[k]. The sequence is p[0..7] = 1 and p[n+8] = p[n+7]^p[n+5]^p[n+3]^p[n] (polynomial x^8+x^7+x^5+x^3+1).
- R6: After codeword bit 8175 (flagged by `cw_last_i`), two zero bits follow, scrambled by p[8158] and p[8159].
- R7: A frame is exactly 8192 output bits and consumes exactly 8176 codeword bits. The next frame's marker is presented right after it.
- R8: While `frame_valid_o` is high and `frame_ready_i` is low, the output bit and start flag hold, and no counter or scrambler state advances. The emitted stream therefore does not depend on stall patterns.
- R9: After reset, the output presents the first marker bit (value 0, `frame_sof_o` high), `cw_ready_o` is low, and the encoder input presents position 0 (valid, value 0) with `usr_ready_o` low.
- R10: `cw_ready_o` stays low while marker bits are being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| usr_bit_i | input | 1 | User information bit |
| usr_valid_i | input | 1 | User bit valid |
| usr_ready_o | output | 1 | User bit accepted |
| enc_bit_o | output | 1 | Information bit to encoder |
| enc_valid_o | output | 1 | Encoder information valid |
| enc_last_o | output | 1 | Last position of encoder block |
| enc_ready_i | input | 1 | Encoder accepts information bit |
| cw_bit_i | input | 1 | Codeword bit from encoder |
| cw_valid_i | input | 1 | Codeword bit valid |
| cw_last_i | input | 1 | Final bit of codeword |
| cw_ready_o | output | 1 | Codeword bit accepted |
| frame_bit_o | output | 1 | Serial frame bit |
| frame_valid_o | output | 1 | Frame bit valid |
| frame_sof_o | output | 1 | First bit of frame |
| frame_ready_i | input | 1 | Downstream accepts frame bit |

## Verification
Four codeword patterns are used, each separating one class of fault:
- A codeword of zeros whose 18 leading bits are ones. A wrong drop count or a leak of fill bits shows up against the pure scrambling sequence.
- A random codeword with no stalls. This checks bit order and scrambler alignment.
- A random codeword under random output and input stalls. This exposes any counter or scrambler that steps on a stalled cycle.
- An all-ones codeword under stalls. This separates inverted or missing scrambling on the fill bits.

The information side runs two blocks back to back with random user gaps and encoder stalls. This checks that the zero insertion repeats at each block and that no user bit is dropped or duplicated.

// File: rtl/ldpc_frm_pkg.sv
package ldpc_frm_pkg;
  typedef enum logic [1:0] {PH_MARK, PH_BODY, PH_FILL} phase_e;
endpackage

// File: rtl/frm_vfill.sv
module frm_vfill #(
  parameter int INFO_W  = 7136,
  parameter int VFILL_W = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic usr_bit_i,
  input  logic usr_valid_i,
  output logic usr_ready_o,
  output logic enc_bit_o,
  output logic enc_valid_o,
  output logic enc_last_o,
  input  logic enc_ready_i
);
  localparam int ENC_K = INFO_W + VFILL_W;
  localparam int PW = $clog2(ENC_K);
  localparam logic [PW-1:0] FILL_END = PW'(VFILL_W);
  localparam logic [PW-1:0] POS_LAST = PW'(ENC_K - 1);

  logic [PW-1:0] pos_q;
  logic in_fill;

  assign in_fill     = pos_q < FILL_END;
  assign enc_valid_o = in_fill | usr_valid_i;
  assign enc_bit_o   = in_fill ? 1'b0 : usr_bit_i;
  assign usr_ready_o = ~in_fill & enc_ready_i;
  assign enc_last_o  = pos_q == POS_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else if (enc_valid_o && enc_ready_i) pos_q <= enc_last_o ? '0 : pos_q + 1'b1;
  end

  AST_INFO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_o && enc_ready_i && enc_last_o |=> !usr_ready_o && !enc_bit_o && enc_valid_o); // R1
endmodule

// File: rtl/frm_prn.sv
module frm_prn #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'b1010_1001,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  output logic prn_o
);
  logic [W-1:0] sr_q;

  assign prn_o = sr_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= SEED;
    else if (load_i) sr_q <= SEED;
    else if (step_i) sr_q <= {^(sr_q & TAPS), sr_q[W-1:1]};
  end
endmodule

// File: rtl/frm_sequencer.sv
module frm_sequencer
  import ldpc_frm_pkg::*;
#(
  parameter int          CW_W      = 8176,
  parameter int          VFILL_W   = 18,
  parameter int          ZFILL_W   = 2,
  parameter int          SYNC_W    = 32,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 32'h1ACF_FC1D
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cw_bit_i,
  input  logic cw_valid_i,
  input  logic cw_last_i,
  output logic cw_ready_o,
  input  logic prn_i,
  output logic prn_load_o,
  output logic prn_step_o,
  output logic frame_bit_o,
  output logic frame_valid_o,
  output logic frame_sof_o,
  input  logic frame_ready_i
);
  localparam int CNT_W = $clog2(CW_W);
  localparam logic [CNT_W-1:0] DROP_END  = CNT_W'(VFILL_W);
  localparam logic [CNT_W-1:0] CW_LAST   = CNT_W'(CW_W - 1);
  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_W - 1);
  localparam logic [CNT_W-1:0] ZF_LAST   = CNT_W'(ZFILL_W - 1);

  phase_e phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SYNC_W-1:0] mark_q;
  logic xfer, cw_take;

  always_comb begin
    frame_valid_o = 1'b0;
    frame_bit_o   = 1'b0;
    frame_sof_o   = 1'b0;
    cw_ready_o    = 1'b0;
    prn_load_o    = 1'b0;
    unique case (phase_q)
      PH_MARK: begin
        frame_valid_o = 1'b1;
        frame_bit_o   = mark_q[SYNC_W-1];
        frame_sof_o   = cnt_q == '0;
        prn_load_o    = 1'b1;
      end
      PH_BODY: begin
        if (cnt_q < DROP_END) begin
          cw_ready_o = 1'b1;  // virtual fill: consume, never send
        end else begin
          frame_valid_o = cw_valid_i;
          frame_bit_o   = cw_bit_i ^ prn_i;
          cw_ready_o    = frame_ready_i;
        end
      end
      PH_FILL: begin
        frame_valid_o = 1'b1;
        frame_bit_o   = prn_i;
      end
      default: ;
    endcase
  end

  assign xfer       = frame_valid_o & frame_ready_i;
  assign cw_take    = cw_valid_i & cw_ready_o;
  assign prn_step_o = xfer & (phase_q != PH_MARK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_MARK;
      cnt_q   <= '0;
      mark_q  <= SYNC_WORD;
    end else begin
      unique case (phase_q)
        PH_MARK: if (xfer) begin
          mark_q <= mark_q << 1;
          if (cnt_q == SYNC_LAST) begin
            phase_q <= PH_BODY;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_BODY: if (cw_take) begin
          if (cnt_q == CW_LAST) begin
            phase_q <= PH_FILL;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_FILL: if (xfer) begin
          if (cnt_q == ZF_LAST) begin
            phase_q <= PH_MARK;
            cnt_q   <= '0;
            mark_q  <= SYNC_WORD;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_MARK;
      endcase
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o && !frame_ready_i |=> frame_valid_o && $stable(frame_bit_o) && $stable(frame_sof_o)); // R8
  AST_SOF_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sof_o && frame_ready_i |=> !frame_sof_o); // R3
  AST_LAST_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_take && cw_last_i |-> phase_q == PH_BODY && cnt_q == CW_LAST); // R7
  AST_FILL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_take && cw_last_i |=> frame_valid_o && !cw_ready_o && !frame_sof_o); // R6
endmodule

// File: rtl/ldpc_frm_top.sv
module ldpc_frm_top #(
  parameter int INFO_W  = 7136,
  parameter int VFILL_W = 18,
  parameter int PAR_W   = 1022,
  parameter int ZFILL_W = 2,
  parameter int SYNC_W  = 32,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 32'h1ACF_FC1D,
  parameter int PRN_W   = 8,
  parameter logic [PRN_W-1:0] PRN_TAPS = 8'b1010_1001,
  parameter logic [PRN_W-1:0] PRN_SEED = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic usr_bit_i,
  input  logic usr_valid_i,
  output logic usr_ready_o,
  output logic enc_bit_o,
  output logic enc_valid_o,
  output logic enc_last_o,
  input  logic enc_ready_i,
  input  logic cw_bit_i,
  input  logic cw_valid_i,
  input  logic cw_last_i,
  output logic cw_ready_o,
  output logic frame_bit_o,
  output logic frame_valid_o,
  output logic frame_sof_o,
  input  logic frame_ready_i
);
  localparam int CW_W = INFO_W + VFILL_W + PAR_W;

  logic prn_bit, prn_load, prn_step;

  frm_vfill #(.INFO_W(INFO_W), .VFILL_W(VFILL_W)) u_vfill (
    .clk_i, .rst_ni,
    .usr_bit_i, .usr_valid_i, .usr_ready_o,
    .enc_bit_o, .enc_valid_o, .enc_last_o, .enc_ready_i
  );

  frm_prn #(.W(PRN_W), .TAPS(PRN_TAPS), .SEED(PRN_SEED)) u_prn (
    .clk_i, .rst_ni,
    .load_i(prn_load), .step_i(prn_step), .prn_o(prn_bit)
  );

  frm_sequencer #(
    .CW_W(CW_W), .VFILL_W(VFILL_W), .ZFILL_W(ZFILL_W),
    .SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD)
  ) u_seq (
    .clk_i, .rst_ni,
    .cw_bit_i, .cw_valid_i, .cw_last_i, .cw_ready_o,
    .prn_i(prn_bit), .prn_load_o(prn_load), .prn_step_o(prn_step),
    .frame_bit_o, .frame_valid_o, .frame_sof_o, .frame_ready_i
  );

  AST_SEED_AT_BODY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prn_load) |-> prn_bit); // R5
endmodule

// File: tb/tb_ldpc_frm_top.sv
module tb_ldpc_frm_top;
  localparam int INFO_W = 7136, VF = 18, ENC_K = 7154, CW_W = 8176;
  localparam int BODY_W = CW_W - VF, PRN_N = 8160, FRM_W = 8192;
  localparam logic [31:0] SYNC = 32'h1ACF_FC1D;

  logic clk_i = 0, rst_ni = 0;
  logic usr_bit_i = 0, usr_valid_i = 0, enc_ready_i = 0;
  logic cw_bit_i = 0, cw_valid_i = 0, cw_last_i = 0, frame_ready_i = 0;
  logic usr_ready_o, enc_bit_o, enc_valid_o, enc_last_o, cw_ready_o;
  logic frame_bit_o, frame_valid_o, frame_sof_o;

  int checks = 0, errors = 0;
  bit done = 0;
  bit prn_seq [PRN_N];
  bit cw [CW_W];
  bit exp_b [FRM_W];
  bit ub [2*INFO_W];

  ldpc_frm_top dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic void build_prn();
    for (int n = 0; n < 8; n++) prn_seq[n] = 1'b1;
    for (int n = 0; n + 8 < PRN_N; n++)
      prn_seq[n+8] = prn_seq[n+7] ^ prn_seq[n+5] ^ prn_seq[n+3] ^ prn_seq[n];
  endfunction

  function automatic void build_exp();
    for (int i = 0; i < 32; i++) exp_b[i] = SYNC[31-i];
    for (int j = 0; j < BODY_W; j++) exp_b[32+j] = cw[VF+j] ^ prn_seq[j];
    for (int j = BODY_W; j < PRN_N; j++) exp_b[32+j] = prn_seq[j];
  endfunction

  task automatic run_info();
    int et = 0, ui = 0;
    int bad_fill = 0, bad_hold = 0, bad_data = 0, bad_last = 0;
    bit uclr = 0;
    for (int i = 0; i < 2*INFO_W; i++) ub[i] = 1'($urandom);
    while (et < 2*ENC_K) begin
      @(negedge clk_i);
      if (uclr) begin usr_valid_i = 0; uclr = 0; end
      if (!usr_valid_i && ui < 2*INFO_W && ($urandom % 100) < 70) begin
        usr_valid_i = 1; usr_bit_i = ub[ui];
      end
      enc_ready_i = ($urandom % 100) < 60;
      #1;
      if ((et % ENC_K) < VF && usr_ready_o) bad_hold++;
      if (enc_valid_o && enc_ready_i) begin
        if ((et % ENC_K) < VF) begin
          if (enc_bit_o) bad_fill++;
        end else if (!(usr_valid_i && usr_ready_o) || enc_bit_o !== ub[ui]) bad_data++;
        if (enc_last_o !== ((et % ENC_K) == ENC_K - 1)) bad_last++;
        et++;
      end
      if (usr_valid_i && usr_ready_o) begin ui++; uclr = 1; end
    end
    @(negedge clk_i);
    usr_valid_i = 0; enc_ready_i = 0;
    chk(bad_fill == 0, "R1 zero fill positions", bad_fill, 0);
    chk(bad_hold == 0, "R1 user held during fill", bad_hold, 0);
    chk(bad_data == 0, "R1 user bits in order", bad_data, 0);
    chk(bad_last == 0, "R1 block last flag", bad_last, 0);
    chk(ui == 2*INFO_W, "R1 user bits consumed", ui, 2*INFO_W);
  endtask

  task automatic run_frame(input int vpct, input int rpct, input string tg);
    int oi = 0, ci = 0;
    int m_mark = 0, m_sof = 0, m_body = 0, m_fill = 0, m_blk = 0;
    bit clr = 0;
    build_exp();
    while (oi < FRM_W) begin
      @(negedge clk_i);
      if (clr) begin cw_valid_i = 0; clr = 0; end
      if (!cw_valid_i && ci < CW_W && ($urandom % 100) < vpct) begin
        cw_valid_i = 1; cw_bit_i = cw[ci]; cw_last_i = (ci == CW_W - 1);
      end
      frame_ready_i = ($urandom % 100) < rpct;
      #1;
      if (oi < 32 && cw_ready_o) m_blk++;
      if (cw_valid_i && cw_ready_o) begin ci++; clr = 1; end
      if (frame_valid_o && frame_ready_i) begin
        if (frame_sof_o !== (oi == 0)) m_sof++;
        if (frame_bit_o !== exp_b[oi]) begin
          if (oi < 32) m_mark++;
          else if (oi < 32 + BODY_W) m_body++;
          else m_fill++;
        end
        oi++;
      end
    end
    @(negedge clk_i);
    cw_valid_i = 0; frame_ready_i = 0;
    #1;
    chk(m_mark == 0, "R2 marker bits", m_mark, 0);
    chk(m_sof == 0, "R3 start flag", m_sof, 0);
    chk(m_body == 0, tg, m_body, 0);
    chk(m_fill == 0, "R6 scrambled zero fill", m_fill, 0);
    chk(m_blk == 0, "R10 codeword blocked in marker", m_blk, 0);
    chk(ci == CW_W, "R7 codeword bits consumed", ci, CW_W);
    chk(frame_valid_o && frame_sof_o, "R7 next frame follows", int'(frame_sof_o), 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    build_prn();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    chk(frame_valid_o && frame_sof_o, "R9 reset frame start", int'(frame_sof_o), 1);
    chk(frame_bit_o == 1'b0, "R9 reset first marker bit", int'(frame_bit_o), 0);
    chk(!cw_ready_o, "R9 reset codeword ready", int'(cw_ready_o), 0);
    chk(enc_valid_o && !enc_bit_o && !usr_ready_o, "R9 reset encoder side",
        int'(usr_ready_o), 0);

    run_info();

    // R4: ones only in the dropped positions, so output body must equal p[k]
    for (int i = 0; i < CW_W; i++) cw[i] = (i < VF);
    run_frame(100, 100, "R4 virtual fill dropped");
    for (int i = 0; i < CW_W; i++) cw[i] = 1'($urandom);
    run_frame(100, 100, "R5 scrambled body");
    for (int i = 0; i < CW_W; i++) cw[i] = 1'($urandom);
    run_frame(60, 50, "R8 body under stalls");
    for (int i = 0; i < CW_W; i++) cw[i] = 1'b1;
    run_frame(80, 70, "R8 ones under stalls");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule